// File: doc/BRIEF.md
# Multi-Mode Test Pattern Generator

This block is a design-for-test traffic source for a parallel transmit path. It makes a 64-bit word each clock, so a serializer can be exercised with no protocol logic above it. Configuration inputs pick one of four pattern families: a pseudo-random bit sequence (PRBS), a repeating user word, an alternating level pattern, or an all-zero word. They also pick the PRBS order, the line encoding (NRZ or PAM4), the user word length and the alternating run length.

The PRBS engine works out all 64 bits of a word in one cycle from a 58-bit history. In NRZ mode the bits go out as they are. In PAM4 mode the same bit stream is cut into pairs, and each pair is Gray coded into a 2-bit symbol. The quaternary pattern for an order is therefore a function of the order setting and the encoding flag together, and there is no separate quaternary setting. Any change to the mode fields restarts the pattern from its start state. A seed write loads a chosen PRBS history.

Top module: `tpg_top`

## Requirements
- R1: After reset, `out_valid` is 0.
- R2: `out_valid` follows `enable` with a one-cycle delay. A word computed while `enable` was high appears one cycle later. While `enable` is low, the pattern state holds, and the stream resumes where it stopped.
- R3: For `cfg_fam`=0 and `cfg_pam4`=0, `out_data` carries a continuous PRBS bit stream, with the earliest bit in bit 0. `cfg_order` codes 0..6 select these recurrences: s[n] = s[n-6]^s[n-7]; s[n-5]^s[n-9]; s[n-9]^s[n-11]; s[n-12]^s[n-13]^s[n-2]^s[n-1]; s[n-18]^s[n-23]; s[n-28]^s[n-31]; s[n-39]^s[n-58]. Code 7 behaves as code 6.
- R4: For `cfg_fam`=0 and `cfg_pam4`=1, the same bit stream is taken in pairs (a earlier, b later). Symbol k occupies bits [2k+1:2k] and equals {a, a^b}. This gives the Gray map 00→0, 01→1, 11→2, 10→3.
- R5: For `cfg_fam`=1, `user_pat` bit i is sent i-th and repeats with period 32, 64 or 128 bits, for `cfg_ulen` codes 0, 1 and 2 (code 3 acts as 128).
- R6: For `cfg_fam`=2, the output is a run of ones and then a run of zeros, alternating. Each run is 1, 8 or 64 bits long for `cfg_run` codes 0, 1 and 2 (code 3 acts as 64). The stream begins with a run of ones.
- R7: A change in any of `cfg_fam`, `cfg_order`, `cfg_pam4`, `cfg_ulen` or `cfg_run` restarts the stream in the cycle the change is sampled. The PRBS history becomes all ones and the user and alternating positions return to zero.
- R8: A `seed_wr` pulse loads `seed_val` as the PRBS history. Seed bit k is the bit taken as sent k+1 positions before the next output bit. If the low w bits of the seed are zero (w = the selected order), the history is set to all ones instead. The history is never all zero.
- R9: `cfg_pam4` has no effect on the user and alternating families.
- R10: For `cfg_fam`=3, every valid word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Produce a word this cycle |
| cfg_fam | input | 2 | Family: 0 PRBS, 1 user, 2 alternating, 3 zero |
| cfg_order | input | 3 | PRBS order code |
| cfg_pam4 | input | 1 | 1 selects PAM4 symbol form for PRBS |
| cfg_ulen | input | 2 | User pattern length code |
| cfg_run | input | 2 | Alternating run length code |
| user_pat | input | 128 | User pattern, bit 0 sent first |
| seed_wr | input | 1 | Load `seed_val` into the PRBS history |
| seed_val | input | 58 | PRBS seed |
| out_valid | output | 1 | `out_data` holds a fresh word |
| out_data | output | 64 | Pattern word, earliest bit in bit 0 |

## Verification
The bench tests PRBS continuity across enable gaps. A design that reset or skipped state while idle would show a broken sequence at the next word. It changes the encoding flag mid-stream without dropping `enable`, and expects the restarted sequence in that same cycle. A restart one cycle late would leave one old word. It loads a seed that is zero only in the bits the selected order uses. A design that tested the whole seed for zero would lock the PRBS7 generator into a stream of zeros. It also checks the 128-bit user word, where swapping the two halves in the wrong order gives a visible mismatch, and the 64-bit alternating run, which must flip whole words.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int unsigned HIST_W = 58;

    typedef enum logic [1:0] {
        FAM_PRBS = 2'd0,
        FAM_USER = 2'd1,
        FAM_ALT  = 2'd2,
        FAM_ZERO = 2'd3
    } fam_e;

    typedef struct packed {
        logic [1:0] fam;
        logic [2:0] ord;
        logic       pam4;
        logic [1:0] ulen;
        logic [1:0] run;
    } mode_t;

    typedef struct packed {
        logic [7:0] t1;
        logic [7:0] t2;
        logic [7:0] t3;
        logic [7:0] t4;
    } taps_t;

    // Feedback delays of each order; zero marks an unused tap.
    function automatic taps_t taps_of(input logic [2:0] ord);
        taps_t t;
        case (ord)
            3'd0:    t = '{8'd6,  8'd7,  8'd0, 8'd0};
            3'd1:    t = '{8'd5,  8'd9,  8'd0, 8'd0};
            3'd2:    t = '{8'd9,  8'd11, 8'd0, 8'd0};
            3'd3:    t = '{8'd12, 8'd13, 8'd2, 8'd1};
            3'd4:    t = '{8'd18, 8'd23, 8'd0, 8'd0};
            3'd5:    t = '{8'd28, 8'd31, 8'd0, 8'd0};
            default: t = '{8'd39, 8'd58, 8'd0, 8'd0};
        endcase
        return t;
    endfunction

    function automatic int unsigned order_len(input logic [2:0] ord);
        case (ord)
            3'd0:    return 7;
            3'd1:    return 9;
            3'd2:    return 11;
            3'd3:    return 13;
            3'd4:    return 23;
            3'd5:    return 31;
            default: return 58;
        endcase
    endfunction

endpackage

// File: rtl/tpg_prbs_step.sv
module tpg_prbs_step
    import tpg_pkg::*;
#(
    parameter int unsigned W = 64,
    parameter int unsigned L = HIST_W
) (
    input  logic [2:0]   ord_i,
    input  logic [L-1:0] hist_i,
    output logic [W-1:0] bits_o,
    output logic [L-1:0] hist_o
);
    localparam int unsigned SEQ_W = L + W;

    always_comb begin
        logic [SEQ_W-1:0] seq;
        taps_t            tp;
        tp  = taps_of(ord_i);
        seq = '0;
        // Oldest history bit sits lowest in the unrolled sequence.
        for (int k = 0; k < L; k++) begin
            seq[L-1-k] = hist_i[k];
        end
        for (int j = 0; j < W; j++) begin
            logic fb;
            fb = seq[L+j-int'(tp.t1)] ^ seq[L+j-int'(tp.t2)];
            if (tp.t3 != 8'd0) fb = fb ^ seq[L+j-int'(tp.t3)];
            if (tp.t4 != 8'd0) fb = fb ^ seq[L+j-int'(tp.t4)];
            seq[L+j] = fb;
        end
        bits_o = seq[SEQ_W-1:L];
        for (int k = 0; k < L; k++) begin
            hist_o[k] = seq[SEQ_W-1-k];
        end
    end

endmodule

// File: rtl/tpg_pam4_gray.sv
module tpg_pam4_gray #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] bits_i,
    output logic [W-1:0] sym_o
);
    localparam int unsigned NSYM = W / 2;

    for (genvar k = 0; k < NSYM; k++) begin : g_sym
        // Earlier bit is the symbol MSB; Gray fold on the LSB.
        assign sym_o[2*k+1] = bits_i[2*k];
        assign sym_o[2*k]   = bits_i[2*k] ^ bits_i[2*k+1];
    end

    if ((W % 2) != 0) begin : g_odd
        assign sym_o[W-1] = bits_i[W-1];
    end

endmodule

// File: rtl/tpg_fixed_word.sv
module tpg_fixed_word #(
    parameter int unsigned W     = 64,
    parameter int unsigned UW    = 128,
    parameter int unsigned POS_W = $clog2(UW)
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic [1:0]       ulen_i,
    input  logic [1:0]       run_i,
    input  logic [UW-1:0]    pat_i,
    output logic [W-1:0]     user_o,
    output logic [W-1:0]     alt_o
);
    always_comb begin
        int unsigned len;
        int unsigned sh;
        case (ulen_i)
            2'd0:    len = 32;
            2'd1:    len = 64;
            default: len = 128;
        endcase
        case (run_i)
            2'd0:    sh = 0;
            2'd1:    sh = 3;
            default: sh = 6;
        endcase
        for (int j = 0; j < W; j++) begin
            int unsigned abs_pos;
            abs_pos   = (int'(pos_i) + j) % UW;
            user_o[j] = pat_i[abs_pos % len];
            alt_o[j]  = ~((abs_pos >> sh) & 1);
        end
    end

endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int unsigned W  = 64,
    parameter int unsigned UW = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        cfg_fam,
    input  logic [2:0]        cfg_order,
    input  logic              cfg_pam4,
    input  logic [1:0]        cfg_ulen,
    input  logic [1:0]        cfg_run,
    input  logic [UW-1:0]     user_pat,
    input  logic              seed_wr,
    input  logic [HIST_W-1:0] seed_val,
    output logic              out_valid,
    output logic [W-1:0]      out_data
);
    localparam int unsigned L     = HIST_W;
    localparam int unsigned POS_W = $clog2(UW);
    localparam logic [POS_W-1:0] POS_STEP = POS_W'(W % UW);

    typedef struct packed {
        logic [L-1:0]     hist;
        logic [POS_W-1:0] pos;
        mode_t            mode;
        logic             valid;
        logic [W-1:0]     data;
    } state_t;

    state_t st_d, st_q;

    mode_t            mode_now;
    logic             restart;
    logic [L-1:0]     seed_fix;
    logic [L-1:0]     hist_eff;
    logic [POS_W-1:0] pos_eff;
    logic [W-1:0]     prbs_bits;
    logic [W-1:0]     prbs_sym;
    logic [L-1:0]     prbs_next;
    logic [W-1:0]     user_word;
    logic [W-1:0]     alt_word;
    logic [L-1:0]     hist_now;

    assign mode_now = '{fam: cfg_fam, ord: cfg_order, pam4: cfg_pam4,
                        ulen: cfg_ulen, run: cfg_run};
    assign restart  = (mode_now != st_q.mode);

    always_comb begin
        logic [L-1:0] mask;
        int unsigned  w;
        w = order_len(cfg_order);
        for (int k = 0; k < L; k++) begin
            mask[k] = (k < w);
        end
        seed_fix = ((seed_val & mask) == '0) ? '1 : seed_val;
    end

    assign hist_eff = restart ? '1 : (seed_wr ? seed_fix : st_q.hist);
    assign pos_eff  = restart ? '0 : st_q.pos;
    assign hist_now = st_q.hist;

    tpg_prbs_step #(.W(W), .L(L)) u_step (
        .ord_i  (cfg_order),
        .hist_i (hist_eff),
        .bits_o (prbs_bits),
        .hist_o (prbs_next)
    );

    tpg_pam4_gray #(.W(W)) u_gray (
        .bits_i (prbs_bits),
        .sym_o  (prbs_sym)
    );

    tpg_fixed_word #(.W(W), .UW(UW), .POS_W(POS_W)) u_fixed (
        .pos_i  (pos_eff),
        .ulen_i (cfg_ulen),
        .run_i  (cfg_run),
        .pat_i  (user_pat),
        .user_o (user_word),
        .alt_o  (alt_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.mode  = mode_now;
        st_d.hist  = hist_eff;
        st_d.pos   = pos_eff;
        st_d.valid = enable;
        if (enable) begin
            case (cfg_fam)
                FAM_PRBS: begin
                    st_d.data = cfg_pam4 ? prbs_sym : prbs_bits;
                    st_d.hist = prbs_next;
                end
                FAM_USER: st_d.data = user_word;
                FAM_ALT:  st_d.data = alt_word;
                default:  st_d.data = '0;
            endcase
            st_d.pos = pos_eff + POS_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hist  <= '1;
            st_q.pos   <= '0;
            st_q.mode  <= '0;
            st_q.valid <= 1'b0;
            st_q.data  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
    parameter int unsigned W = 64,
    parameter int unsigned L = 58
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic [1:0]   cfg_fam,
    input logic [1:0]   cfg_ulen,
    input logic [1:0]   cfg_run,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic [L-1:0] hist_now
);
    localparam logic [W-1:0] ALT1 = {(W/2){2'b01}};

    p_valid_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && enable) |=> out_valid);

    p_valid_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !enable) |=> !out_valid);

    p_hist_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hist_now != '0);

    p_user32_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cfg_fam) == 2'd1 && $past(cfg_ulen) == 2'd0)
        |-> (out_data == ((out_data >> 32) | (out_data << (W-32)))));

    p_alt_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cfg_fam) == 2'd2 && $past(cfg_run) == 2'd0)
        |-> (out_data == ALT1));

    p_zero_family_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cfg_fam) == 2'd3) |-> (out_data == '0));

endmodule

bind tpg_top tpg_checker #(.W(W), .L(L)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cfg_fam   (cfg_fam),
    .cfg_ulen  (cfg_ulen),
    .cfg_run   (cfg_run),
    .out_valid (out_valid),
    .out_data  (out_data),
    .hist_now  (hist_now)
);

// File: tb/sim_tpg_top.sv
module sim_tpg_top;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [1:0]    cfg_fam = 2'd0;
    logic [2:0]    cfg_order = 3'd0;
    logic          cfg_pam4 = 1'b0;
    logic [1:0]    cfg_ulen = 2'd0;
    logic [1:0]    cfg_run = 2'd0;
    logic [127:0]  user_pat = '0;
    logic          seed_wr = 1'b0;
    logic [57:0]   seed_val = '0;
    logic          out_valid;
    logic [63:0]   out_data;

    int checks = 0;
    int fails  = 0;

    logic [63:0] qd[$];
    string       qt[$];

    logic [57:0] m_hist;
    int          m_n;

    always #2 clk = ~clk;

    tpg_top u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_fam(cfg_fam),
        .cfg_order(cfg_order), .cfg_pam4(cfg_pam4), .cfg_ulen(cfg_ulen),
        .cfg_run(cfg_run), .user_pat(user_pat), .seed_wr(seed_wr),
        .seed_val(seed_val), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int ord_w(input logic [2:0] o);
        case (o)
            3'd0: return 7;   3'd1: return 9;   3'd2: return 11;
            3'd3: return 13;  3'd4: return 23;  3'd5: return 31;
            default: return 58;
        endcase
    endfunction

    task automatic next_bit(output logic b);
        case (cfg_order)
            3'd0: b = m_hist[5] ^ m_hist[6];
            3'd1: b = m_hist[4] ^ m_hist[8];
            3'd2: b = m_hist[8] ^ m_hist[10];
            3'd3: b = m_hist[11] ^ m_hist[12] ^ m_hist[1] ^ m_hist[0];
            3'd4: b = m_hist[17] ^ m_hist[22];
            3'd5: b = m_hist[27] ^ m_hist[30];
            default: b = m_hist[38] ^ m_hist[57];
        endcase
        m_hist = {m_hist[56:0], b};
    endtask

    task automatic model_word(output logic [63:0] w);
        logic [63:0] raw;
        int len;
        int run;
        len = (cfg_ulen == 2'd0) ? 32 : (cfg_ulen == 2'd1) ? 64 : 128;
        run = (cfg_run == 2'd0) ? 1 : (cfg_run == 2'd1) ? 8 : 64;
        for (int j = 0; j < 64; j++) begin
            logic b;
            case (cfg_fam)
                2'd0: begin next_bit(b); raw[j] = b; end
                2'd1: raw[j] = user_pat[(m_n + j) % len];
                2'd2: raw[j] = (((m_n + j) / run) % 2) == 0;
                default: raw[j] = 1'b0;
            endcase
        end
        m_n = m_n + 64;
        w = raw;
        if (cfg_fam == 2'd0 && cfg_pam4) begin
            for (int k = 0; k < 32; k++) begin
                w[2*k+1] = raw[2*k];
                w[2*k]   = raw[2*k] ^ raw[2*k+1];
            end
        end
    endtask

    task automatic emit(input string tag);
        logic [63:0] w;
        @(negedge clk);
        seed_wr = 1'b0;
        enable  = 1'b1;
        model_word(w);
        qd.push_back(w);
        qt.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seed_wr = 1'b0;
            enable  = 1'b0;
        end
    endtask

    task automatic cfg_step(input logic [1:0] f, input logic [2:0] o,
                            input logic p, input logic [1:0] ul,
                            input logic [1:0] rn, input bit en,
                            input string tag);
        logic [63:0] w;
        @(negedge clk);
        seed_wr = 1'b0;
        if (f != cfg_fam || o != cfg_order || p != cfg_pam4 ||
            ul != cfg_ulen || rn != cfg_run) begin
            m_hist = '1;
            m_n    = 0;
        end
        cfg_fam = f; cfg_order = o; cfg_pam4 = p; cfg_ulen = ul; cfg_run = rn;
        enable = en;
        if (en) begin
            model_word(w);
            qd.push_back(w);
            qt.push_back(tag);
        end
    endtask

    task automatic load_seed(input logic [57:0] s);
        logic [57:0] mask;
        @(negedge clk);
        enable   = 1'b0;
        seed_wr  = 1'b1;
        seed_val = s;
        mask = '0;
        for (int k = 0; k < ord_w(cfg_order); k++) mask[k] = 1'b1;
        m_hist = ((s & mask) == '0) ? '1 : s;
    endtask

    // Monitor: compares each produced word with the oldest expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (qd.size() > 0) begin
                    logic [63:0] e;
                    string t;
                    e = qd.pop_front();
                    t = qt.pop_front();
                    checks++;
                    if (out_valid !== 1'b1 || out_data !== e) begin
                        fails++;
                        $display("FAIL %s: valid=%b data=%h expected valid=1 data=%h",
                                 t, out_valid, out_data, e);
                    end
                end else if (out_valid !== 1'b0) begin
                    checks++;
                    fails++;
                    $display("FAIL R2: valid=%b expected 0 while idle", out_valid);
                end
            end
        end
    end

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_hist   = '1;
        m_n      = 0;
        user_pat = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: valid=%b expected 0", out_valid);
        end

        // R3 PRBS7 NRZ, with gaps for R2 continuity
        emit("R3 prbs7");
        emit("R3 prbs7");
        idle(3);
        emit("R2 resume");
        emit("R2 resume");
        // R3 other orders
        cfg_step(2'd0, 3'd1, 1'b0, 2'd0, 2'd0, 1'b1, "R3 prbs9");
        emit("R3 prbs9");
        cfg_step(2'd0, 3'd3, 1'b0, 2'd0, 2'd0, 1'b1, "R3 prbs13");
        emit("R3 prbs13");
        cfg_step(2'd0, 3'd5, 1'b0, 2'd0, 2'd0, 1'b1, "R3 prbs31");
        emit("R3 prbs31");
        cfg_step(2'd0, 3'd6, 1'b0, 2'd0, 2'd0, 1'b1, "R3 prbs58");
        emit("R3 prbs58");
        emit("R3 prbs58");
        // R4 PAM4 form, R7 change while enabled
        cfg_step(2'd0, 3'd6, 1'b1, 2'd0, 2'd0, 1'b1, "R7 restart pam4");
        emit("R4 prbs58q");
        cfg_step(2'd0, 3'd1, 1'b1, 2'd0, 2'd0, 1'b1, "R4 prbs9q");
        emit("R4 prbs9q");
        // R8 seeds
        cfg_step(2'd0, 3'd4, 1'b0, 2'd0, 2'd0, 1'b0, "");
        load_seed(58'h0000_0000_0A5_C3E1);
        emit("R8 seed prbs23");
        emit("R8 seed prbs23");
        cfg_step(2'd0, 3'd0, 1'b0, 2'd0, 2'd0, 1'b0, "");
        load_seed(58'h3FF_FFFF_FFFF_FF80);
        emit("R8 masked zero seed");
        // R5 user lengths, R9 pam4 ignored
        cfg_step(2'd1, 3'd0, 1'b0, 2'd0, 2'd0, 1'b1, "R5 user32");
        emit("R5 user32");
        cfg_step(2'd1, 3'd0, 1'b0, 2'd1, 2'd0, 1'b1, "R5 user64");
        cfg_step(2'd1, 3'd0, 1'b0, 2'd2, 2'd0, 1'b1, "R5 user128");
        emit("R5 user128");
        emit("R5 user128");
        idle(1);
        emit("R5 user128 resume");
        cfg_step(2'd1, 3'd0, 1'b1, 2'd2, 2'd0, 1'b1, "R9 user pam4");
        emit("R9 user pam4");
        // R6 alternating runs
        cfg_step(2'd2, 3'd0, 1'b0, 2'd0, 2'd0, 1'b1, "R6 run1");
        cfg_step(2'd2, 3'd0, 1'b0, 2'd0, 2'd1, 1'b1, "R6 run8");
        cfg_step(2'd2, 3'd0, 1'b0, 2'd0, 2'd2, 1'b1, "R6 run64");
        emit("R6 run64");
        emit("R6 run64");
        cfg_step(2'd2, 3'd0, 1'b1, 2'd0, 2'd2, 1'b1, "R9 alt pam4");
        emit("R9 alt pam4");
        // R10 zero family
        cfg_step(2'd3, 3'd0, 1'b0, 2'd0, 2'd0, 1'b1, "R10 zero");
        emit("R10 zero");
        idle(4);
        checks++;
        if (qd.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d words missing, expected 0", qd.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule